// File: doc/BRIEF.md
# Block Transfer Sequencer

This engine moves a block of N words through a serial port's transmit and receive FIFOs without a processor servicing every word. A single start command supplies the word count and three choices: whether transmit words come from a streaming source, whether received words go to a streaming sink, and whether items are wide (16 bits) or narrow (8 bits). Without a source, the engine fills the transmit side with an all-ones dummy word. Without a sink, it still drains the receive FIFO and drops what it reads.

Transmit refills happen in bounded passes. A pass opens only while the transmit FIFO holds half its depth or less. It then pushes words until it reaches the per-pass limit, the block runs out of words, the FIFO reports full, or the number of words pushed but not yet popped reaches the FIFO depth. That last cap means the receive FIFO can never overrun. The transfer ends on the receive count: once the N-th received word has been popped, the engine pulses done and returns to idle.

The per-pass limit is clamped to the range from half the depth to the full depth.

Top module: `blk_xfer_seq`

## Requirements
- R1: With no source selected, every pushed transmit word equals 16'hFFFF in both widths, and src_ready stays low.
- R2: With no sink selected, sink_valid stays low and every received word is still popped, so exactly N pops occur and the receive FIFO ends empty.
- R3: A refill pass starts only after a cycle in which txf_half was high. A pass pushes at most TXLIMIT words (4 by default), in consecutive cycles while the source is ready, and no word is pushed while txf_full is high.
- R4: The number of words pushed but not yet popped never exceeds DEPTH (8), so the receive FIFO never overflows, even with a stalled sink.
- R5: done is raised in the cycle after the pop of the N-th received word and not earlier; busy falls in that same cycle.
- R6: Wide mode (start_wide=1) passes all 16 bits. Narrow mode pushes source bits [7:0] zero-extended and presents receive bits [7:0] zero-extended on sink_data.
- R7: A start request while busy is ignored: the word count, mode and completion of the running transfer are unchanged.
- R8: done is a one-cycle pulse, given once per transfer. A start with count 0 pulses done in the next cycle, pushes nothing, and leaves busy low.
- R9: Source words are taken on src_valid && src_ready and pushed in arrival order. Received words reach the sink in FIFO order, one per sink_valid && sink_ready.
- R10: After reset, busy, done, txf_push and rxf_pop are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, taken only when idle |
| start_count | input | CNT_W | Number of words N |
| start_src | input | 1 | 1: take transmit words from the source port; 0: dummy fill |
| start_sink | input | 1 | 1: deliver received words to the sink port; 0: discard |
| start_wide | input | 1 | 1: 16-bit items; 0: 8-bit items |
| src_valid | input | 1 | Source word available |
| src_data | input | DATA_W | Source word |
| src_ready | output | 1 | Engine takes the source word this cycle |
| txf_full | input | 1 | Transmit FIFO full |
| txf_half | input | 1 | Transmit FIFO at or below half depth |
| txf_push | output | 1 | Push a word into the transmit FIFO |
| txf_data | output | DATA_W | Word pushed |
| rxf_empty | input | 1 | Receive FIFO empty |
| rxf_data | input | DATA_W | Head word of the receive FIFO |
| rxf_pop | output | 1 | Pop the receive FIFO head |
| sink_valid | output | 1 | Received word offered to the sink |
| sink_data | output | DATA_W | Received word |
| sink_ready | input | 1 | Sink accepts the word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bound checker watches every cycle for the properties that follow from the port traffic alone:
- the in-flight count stays within the FIFO depth;
- the pushes in a pass stay within the limit;
- a pass opens only after half-empty, and nothing is pushed into a full FIFO;
- dummy words are all ones;
- narrow sink words have a clear upper byte;
- done lasts a single cycle while the engine is idle.

The bench's scenarios run a looped-back FIFO model, and only they can show the rest. That covers the end-to-end data order and value transforms, the exact completion cycle relative to the last pop, and the zero-count case. It also covers a start ignored mid-transfer and the absence of overrun under a fast link with a stalled sink.

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 16,
  parameter int DEPTH   = 8,
  parameter int TXLIMIT = 4,
  parameter int BYTE_W  = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  start_count,
  input  logic              start_src,
  input  logic              start_sink,
  input  logic              start_wide,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  input  logic              txf_full,
  input  logic              txf_half,
  output logic              txf_push,
  output logic [DATA_W-1:0] txf_data,
  input  logic              rxf_empty,
  input  logic [DATA_W-1:0] rxf_data,
  output logic              rxf_pop,
  output logic              sink_valid,
  output logic [DATA_W-1:0] sink_data,
  input  logic              sink_ready,
  output logic              busy,
  output logic              done
);
  localparam int LIM = (TXLIMIT < DEPTH/2) ? DEPTH/2 : ((TXLIMIT > DEPTH) ? DEPTH : TXLIMIT);
  localparam int IW  = $clog2(DEPTH + 1);
  localparam logic [DATA_W-1:0] DUMMY    = '1;
  localparam logic [DATA_W-1:0] LOW_MASK = DATA_W'((1 << BYTE_W) - 1);

  logic             busy_q, done_q, src_q, sink_q, wide_q, pass_q;
  logic [CNT_W-1:0] tx_left, rx_left;
  logic [IW-1:0]    infl, pass_cnt;
  logic             can_push, push, rx_avail, last_pop;

  assign can_push = busy_q && pass_q && (tx_left != '0) && (pass_cnt < IW'(LIM))
                    && !txf_full && (infl < IW'(DEPTH));
  assign push      = can_push && (!src_q || src_valid);
  assign src_ready = can_push && src_q;
  assign txf_push  = push;
  assign txf_data  = !src_q ? DUMMY : (wide_q ? src_data : (src_data & LOW_MASK));

  assign rx_avail   = busy_q && (rx_left != '0) && !rxf_empty;
  assign sink_valid = rx_avail && sink_q;
  assign sink_data  = wide_q ? rxf_data : (rxf_data & LOW_MASK);
  assign rxf_pop    = rx_avail && (!sink_q || sink_ready);
  assign last_pop   = rxf_pop && (rx_left == CNT_W'(1));

  assign busy = busy_q;
  assign done = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      src_q    <= 1'b0;
      sink_q   <= 1'b0;
      wide_q   <= 1'b0;
      pass_q   <= 1'b0;
      pass_cnt <= '0;
      tx_left  <= '0;
      rx_left  <= '0;
      infl     <= '0;
    end else if (start && !busy_q) begin
      busy_q   <= (start_count != '0);
      done_q   <= (start_count == '0);
      src_q    <= start_src;
      sink_q   <= start_sink;
      wide_q   <= start_wide;
      pass_q   <= 1'b0;
      pass_cnt <= '0;
      tx_left  <= start_count;
      rx_left  <= start_count;
      infl     <= '0;
    end else begin
      done_q  <= last_pop;
      if (last_pop)
        busy_q <= 1'b0;
      tx_left <= tx_left - CNT_W'(push);
      rx_left <= rx_left - CNT_W'(rxf_pop);
      infl    <= infl + IW'(push) - IW'(rxf_pop);
      if (!pass_q) begin
        pass_cnt <= '0;
        if (busy_q && (tx_left != '0) && txf_half)
          pass_q <= 1'b1;
      end else if (!can_push) begin
        pass_q <= 1'b0;
      end else if (push) begin
        pass_cnt <= pass_cnt + IW'(1);
      end
    end
  end
endmodule

// File: rtl/blk_xfer_seq_chk.sv
module blk_xfer_seq_chk #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int LIM    = 4
)(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              txf_push,
  input logic              txf_full,
  input logic              txf_half,
  input logic [DATA_W-1:0] txf_data,
  input logic              rxf_pop,
  input logic              sink_valid,
  input logic [DATA_W-1:0] sink_data,
  input logic              src_on,
  input logic              wide_on,
  input logic              pass_on
);
  int c_infl;
  int c_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_infl <= 0;
      c_run  <= 0;
    end else begin
      if (done)
        c_infl <= 0;
      else
        c_infl <= c_infl + (txf_push ? 1 : 0) - (rxf_pop ? 1 : 0);
      if (!pass_on)
        c_run <= 0;
      else if (txf_push)
        c_run <= c_run + 1;
    end
  end

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    c_infl <= DEPTH);
  a_r3_pass_limit: assert property (@(posedge clk) disable iff (!rst_n)
    c_run <= LIM);
  a_r3_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    txf_push |-> !txf_full);
  a_r3_pass_opens_half: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass_on) |-> $past(txf_half));
  a_r1_dummy_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (txf_push && !src_on) |-> (txf_data == '1));
  a_r6_narrow_sink: assert property (@(posedge clk) disable iff (!rst_n)
    (sink_valid && !wide_on) |-> (sink_data[DATA_W-1:8] == '0));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LIM(LIM)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .txf_push(txf_push), .txf_full(txf_full), .txf_half(txf_half), .txf_data(txf_data),
  .rxf_pop(rxf_pop), .sink_valid(sink_valid), .sink_data(sink_data),
  .src_on(src_q), .wide_on(wide_q), .pass_on(pass_q)
);

// File: tb/blk_xfer_seq_bench.sv
`timescale 1ns/1ps
module blk_xfer_seq_bench;
  localparam logic [15:0] LINK_XOR = 16'hA5C3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] start_count = '0;
  logic        start_src = 1'b0, start_sink = 1'b0, start_wide = 1'b0;
  logic        src_valid, src_ready;
  logic [15:0] src_data;
  logic        txf_full, txf_half, txf_push;
  logic [15:0] txf_data;
  logic        rxf_empty, rxf_pop;
  logic [15:0] rxf_data;
  logic        sink_valid, sink_ready;
  logic [15:0] sink_data;
  logic        busy, done;

  always #4 clk = ~clk;

  blk_xfer_seq u_blk_xfer_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_count(start_count),
    .start_src(start_src), .start_sink(start_sink), .start_wide(start_wide),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .txf_full(txf_full), .txf_half(txf_half), .txf_push(txf_push), .txf_data(txf_data),
    .rxf_empty(rxf_empty), .rxf_data(rxf_data), .rxf_pop(rxf_pop),
    .sink_valid(sink_valid), .sink_data(sink_data), .sink_ready(sink_ready),
    .busy(busy), .done(done)
  );

  int checks = 0;
  int fails  = 0;

  // FIFO pair with looped-back link
  logic [15:0] txq [8];
  logic [15:0] rxq [8];
  logic [3:0]  tx_wr = '0, tx_rd = '0, rx_wr = '0, rx_rd = '0;
  logic [3:0]  tx_lvl, rx_lvl;
  int          link_div = 3;
  int          cyc = 0;
  logic        ovf = 1'b0;

  assign tx_lvl    = tx_wr - tx_rd;
  assign rx_lvl    = rx_wr - rx_rd;
  assign txf_full  = (tx_lvl == 4'd8);
  assign txf_half  = (tx_lvl <= 4'd4);
  assign rxf_empty = (rx_lvl == 4'd0);
  assign rxf_data  = rxq[rx_rd[2:0]];

  // source and sink stimulus
  logic        src_en = 1'b0, src_gap = 1'b0, sink_bp = 1'b0;
  logic [15:0] src_base = '0;
  int          src_idx = 0;
  assign src_valid  = src_en && (!src_gap || cyc[0]);
  assign src_data   = src_base + 16'(src_idx) * 16'h0101;
  assign sink_ready = !sink_bp || cyc[1];

  // monitors
  logic        mon_clr = 1'b0;
  logic [15:0] push_log [64];
  logic [15:0] sink_log [64];
  int push_cnt = 0, pop_cnt = 0, sink_cnt = 0, done_cnt = 0;
  int run = 0, max_run = 0, max_infl = 0, sv_seen = 0;
  int last_pop_cyc = 0, last_push_cyc = 0, done_cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mon_clr) begin
      push_cnt <= 0; pop_cnt <= 0; sink_cnt <= 0; done_cnt <= 0;
      run <= 0; max_run <= 0; max_infl <= 0; sv_seen <= 0; src_idx <= 0; ovf <= 1'b0;
    end else begin
      if (txf_push) begin
        txq[tx_wr[2:0]] <= txf_data;
        tx_wr <= tx_wr + 4'd1;
        if (push_cnt < 64) push_log[push_cnt] <= txf_data;
        push_cnt <= push_cnt + 1;
        last_push_cyc <= cyc;
        run <= run + 1;
        if (run + 1 > max_run) max_run <= run + 1;
      end else begin
        run <= 0;
      end
      if ((cyc % link_div == 0) && (tx_lvl != 4'd0)) begin
        tx_rd <= tx_rd + 4'd1;
        if (rx_lvl == 4'd8) ovf <= 1'b1;
        else begin
          rxq[rx_wr[2:0]] <= txq[tx_rd[2:0]] ^ LINK_XOR;
          rx_wr <= rx_wr + 4'd1;
        end
      end
      if (rxf_pop) begin
        rx_rd <= rx_rd + 4'd1;
        pop_cnt <= pop_cnt + 1;
        last_pop_cyc <= cyc;
      end
      if (push_cnt - pop_cnt > max_infl) max_infl <= push_cnt - pop_cnt;
      if (sink_valid) sv_seen <= sv_seen + 1;
      if (sink_valid && sink_ready) begin
        if (sink_cnt < 64) sink_log[sink_cnt] <= sink_data;
        sink_cnt <= sink_cnt + 1;
      end
      if (src_valid && src_ready) src_idx <= src_idx + 1;
      if (done) begin
        done_cnt <= done_cnt + 1;
        done_cyc <= cyc;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
  endtask

  task automatic kick(input int n, input bit s, input bit k, input bit w);
    @(negedge clk);
    start = 1'b1; start_count = 16'(n); start_src = s; start_sink = k; start_wide = w;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int t;
    t = 0;
    while (done_cnt == 0 && t < 4000) begin
      @(posedge clk); t++;
    end
    chk(done_cnt != 0, "R5", "done seen before timeout", done_cnt, 1);
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [15:0] src_word(input int k);
    return src_base + 16'(k) * 16'h0101;
  endfunction

  task automatic check_data(input int n, input bit s, input bit w, input string req);
    int bad_push, bad_sink;
    logic [15:0] ep, es;
    bad_push = 0; bad_sink = 0;
    for (int k = 0; k < n; k++) begin
      ep = !s ? 16'hFFFF : (w ? src_word(k) : {8'h00, src_word(k)[7:0]});
      es = w ? (ep ^ LINK_XOR) : {8'h00, ep[7:0] ^ LINK_XOR[7:0]};
      if (push_log[k] !== ep) begin
        if (bad_push == 0) chk(1'b0, req, "pushed word", int'(push_log[k]), int'(ep));
        bad_push++;
      end
      if (sink_log[k] !== es) begin
        if (bad_sink == 0) chk(1'b0, req, "sink word", int'(sink_log[k]), int'(es));
        bad_sink++;
      end
    end
    chk(bad_push == 0, req, "mismatched pushed words", bad_push, 0);
    chk(bad_sink == 0, req, "mismatched sink words", bad_sink, 0);
  endtask

  task automatic t_reset();
    #1;
    chk(busy == 1'b0, "R10", "busy after reset", int'(busy), 0);
    chk(done == 1'b0, "R10", "done after reset", int'(done), 0);
    chk(txf_push == 1'b0, "R10", "txf_push after reset", int'(txf_push), 0);
    chk(rxf_pop == 1'b0, "R10", "rxf_pop after reset", int'(rxf_pop), 0);
  endtask

  task automatic t_wide();
    link_div = 3; src_base = 16'h1234; src_en = 1'b1; src_gap = 1'b0; sink_bp = 1'b0;
    clear_mon();
    kick(20, 1'b1, 1'b1, 1'b1);
    wait_done();
    chk(push_cnt == 20, "R9", "wide push count", push_cnt, 20);
    chk(src_idx == 20, "R9", "source words taken", src_idx, 20);
    chk(sink_cnt == 20, "R9", "sink words", sink_cnt, 20);
    check_data(20, 1'b1, 1'b1, "R9");
    chk(done_cnt == 1, "R8", "single done pulse", done_cnt, 1);
    chk(max_run <= 4, "R3", "longest push burst", max_run, 4);
    chk(max_run == 4, "R3", "full pass reached", max_run, 4);
    chk(max_infl <= 8, "R4", "in-flight peak", max_infl, 8);
    chk(done_cyc == last_pop_cyc + 1, "R5", "done cycle after last pop", done_cyc, last_pop_cyc + 1);
    chk(busy == 1'b0, "R5", "busy after done", int'(busy), 0);
  endtask

  task automatic t_dummy();
    link_div = 2; src_en = 1'b1; src_gap = 1'b0; sink_bp = 1'b0;
    clear_mon();
    kick(10, 1'b0, 1'b1, 1'b1);
    wait_done();
    chk(push_cnt == 10, "R1", "dummy push count", push_cnt, 10);
    chk(src_idx == 0, "R1", "source untouched", src_idx, 0);
    check_data(10, 1'b0, 1'b1, "R1");
  endtask

  task automatic t_nosink();
    link_div = 2; src_base = 16'h0F0F; src_en = 1'b1; src_gap = 1'b0; sink_bp = 1'b0;
    clear_mon();
    kick(12, 1'b1, 1'b0, 1'b1);
    wait_done();
    chk(sv_seen == 0, "R2", "sink_valid cycles", sv_seen, 0);
    chk(pop_cnt == 12, "R2", "discarded pops", pop_cnt, 12);
    chk(rx_lvl == 4'd0, "R2", "receive FIFO drained", int'(rx_lvl), 0);
    chk(done_cnt == 1, "R2", "done without sink", done_cnt, 1);
  endtask

  task automatic t_narrow();
    link_div = 2; src_base = 16'hBE7A; src_en = 1'b1; src_gap = 1'b0; sink_bp = 1'b0;
    clear_mon();
    kick(9, 1'b1, 1'b1, 1'b0);
    wait_done();
    chk(sink_cnt == 9, "R6", "narrow sink words", sink_cnt, 9);
    check_data(9, 1'b1, 1'b0, "R6");
    clear_mon();
    kick(5, 1'b0, 1'b1, 1'b0);
    wait_done();
    check_data(5, 1'b0, 1'b0, "R6");
  endtask

  task automatic t_zero();
    clear_mon();
    @(negedge clk);
    start = 1'b1; start_count = 16'd0; start_src = 1'b1; start_sink = 1'b1; start_wide = 1'b1;
    @(posedge clk); #1;
    chk(done == 1'b1, "R8", "zero count done next cycle", int'(done), 1);
    chk(busy == 1'b0, "R8", "zero count busy", int'(busy), 0);
    @(negedge clk); start = 1'b0;
    @(posedge clk); #1;
    chk(done == 1'b0, "R8", "done pulse width", int'(done), 0);
    repeat (3) @(negedge clk);
    chk(push_cnt == 0, "R8", "zero count pushes", push_cnt, 0);
  endtask

  task automatic t_busy_start();
    link_div = 3; src_base = 16'h4400; src_en = 1'b1; src_gap = 1'b0; sink_bp = 1'b0;
    clear_mon();
    kick(16, 1'b1, 1'b1, 1'b1);
    repeat (6) @(negedge clk);
    start = 1'b1; start_count = 16'd3; start_src = 1'b0; start_sink = 1'b0; start_wide = 1'b0;
    @(negedge clk); start = 1'b0;
    wait_done();
    chk(push_cnt == 16, "R7", "pushes unchanged by late start", push_cnt, 16);
    chk(sink_cnt == 16, "R7", "sink words unchanged", sink_cnt, 16);
    chk(done_cnt == 1, "R7", "one completion", done_cnt, 1);
    check_data(16, 1'b1, 1'b1, "R7");
  endtask

  task automatic t_backpressure();
    link_div = 1; src_base = 16'h7001; src_en = 1'b1; src_gap = 1'b1; sink_bp = 1'b1;
    clear_mon();
    kick(30, 1'b1, 1'b1, 1'b1);
    wait_done();
    chk(ovf == 1'b0, "R4", "receive overrun", int'(ovf), 0);
    chk(max_infl <= 8, "R4", "in-flight peak stalled", max_infl, 8);
    chk(sink_cnt == 30, "R9", "words under backpressure", sink_cnt, 30);
    check_data(30, 1'b1, 1'b1, "R9");
    sink_bp = 1'b0; src_gap = 1'b0;
  endtask

  task automatic t_slow_link();
    link_div = 7; src_base = 16'h0101; src_en = 1'b1; src_gap = 1'b0; sink_bp = 1'b0;
    clear_mon();
    kick(6, 1'b1, 1'b1, 1'b1);
    wait_done();
    chk(done_cyc > last_push_cyc + 1, "R5", "done waits for receive", done_cyc, last_push_cyc + 2);
    chk(pop_cnt == 6, "R5", "pops at completion", pop_cnt, 6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_wide();
    t_dummy();
    t_nosink();
    t_narrow();
    t_zero();
    t_busy_start();
    t_backpressure();
    t_slow_link();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule